// File: doc/BRIEF.md
# Program Counter with Zero-Qualified Branch

This block produces the instruction fetch address for a 16-bit processor whose instruction space is byte addressed and 64 KB in size. Every instruction is two bytes long. The block holds the current address in a register. Each cycle in which the fetch enable is high, the register moves to the next instruction.

A branch is taken only when the control path asserts its branch request and the zero flag from the flag register is also set. On a taken branch the register loads a target instead of the next sequential address. The target is the next sequential address plus the 8-bit signed offset, counted in instructions. The block reports its branch decision as a single combinational bit, so the decoder can flush or redirect in the same cycle.

Top module: `pc_branch_unit`

## Requirements
- R1: A synchronous reset sets `fetch_addr` to 0x0000. The reset takes effect on the next rising clock edge, whatever the other inputs are.
- R2: When `fetch_en` is 1 and no branch is taken, `fetch_addr` increases by 2 at the next rising edge.
- R3: When `fetch_en` is 0, `fetch_addr` keeps its value, even if a branch would be taken.
- R4: `br_taken` is 1 exactly when `br_req` and `zero_flag` are both 1. It is combinational, so it follows the inputs in the same cycle and is 0 for the other three input combinations.
- R5: When `fetch_en` is 1 and `br_taken` is 1, the next `fetch_addr` is (current address + 2) + 2 × offset. The offset is the signed value of `br_offset`.
- R6: `br_offset` is read as 8-bit two's complement and sign-extended. The values 0x80..0xFF move the target backwards by 256..2 bytes.
- R7: All address arithmetic wraps modulo 2^16 and raises no fault. Incrementing 0xFFFE gives 0x0000, and a backward branch taken at 0x0000 lands near the top of the space.
- R8: Bit 0 of `fetch_addr` is always 0.
- R9: A branch request while `zero_flag` is 0, or a set `zero_flag` without a request, results in a plain increment of 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every update happens on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| fetch_en | input | 1 | Allows the address register to update |
| br_req | input | 1 | Branch request from the control path |
| zero_flag | input | 1 | Stored zero flag from the flag register |
| br_offset | input | 8 | Signed branch offset, counted in instructions |
| fetch_addr | output | 16 | Byte address of the instruction being fetched |
| br_taken | output | 1 | 1 when the branch is taken in this cycle |

## Verification
The bench builds the block with its default widths: a 16-bit address and an 8-bit offset. At these widths the bench can sweep all 256 offset values with every combination of branch request and zero flag. It can also walk the address across the top of the space, so both the backward sign extension and the modulo wrap are reached directly rather than inferred.

// File: rtl/pc_branch_unit.sv
module pc_branch_unit #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fetch_en,
  input  logic              br_req,
  input  logic              zero_flag,
  input  logic [OFF_W-1:0]  br_offset,
  output logic [ADDR_W-1:0] fetch_addr,
  output logic              br_taken
);
  localparam int WORD_W = ADDR_W - 1;
  localparam int EXT_W  = WORD_W - OFF_W;
  localparam logic [WORD_W-1:0] RESET_WORD = RESET_ADDR[ADDR_W-1:1];

  logic [WORD_W-1:0] pc_q;
  logic [WORD_W-1:0] seq_w;
  logic [WORD_W-1:0] ofs_w;
  logic [WORD_W-1:0] tgt_w;

  assign ofs_w    = {{EXT_W{br_offset[OFF_W-1]}}, br_offset};
  assign seq_w    = pc_q + WORD_W'(1);
  assign tgt_w    = seq_w + ofs_w;
  assign br_taken = br_req & zero_flag;

  always_ff @(posedge clk) begin
    if (rst)
      pc_q <= RESET_WORD;
    else if (fetch_en)
      pc_q <= br_taken ? tgt_w : seq_w;
  end

  assign fetch_addr = {pc_q, 1'b0};
endmodule

module pc_branch_unit_chk #(
  parameter int ADDR_W = 16,
  parameter int OFF_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              fetch_en,
  input logic              br_req,
  input logic              zero_flag,
  input logic [OFF_W-1:0]  br_offset,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              br_taken
);
  logic [ADDR_W-1:0] byte_ofs;
  assign byte_ofs = {{(ADDR_W-OFF_W-1){br_offset[OFF_W-1]}}, br_offset, 1'b0};

  a_r1_reset_zero: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> fetch_addr == '0);

  a_r2_step_two: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && !br_req) |=> fetch_addr == ADDR_W'($past(fetch_addr) + ADDR_W'(2)));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !fetch_en |=> $stable(fetch_addr));

  a_r5_target: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && br_taken) |=>
      fetch_addr == ADDR_W'($past(fetch_addr) + ADDR_W'(2) + $past(byte_ofs)));

  a_r9_no_zero_no_branch: assert property (@(posedge clk) disable iff (rst)
    (fetch_en && br_req && !zero_flag) |=>
      fetch_addr == ADDR_W'($past(fetch_addr) + ADDR_W'(2)));
endmodule

bind pc_branch_unit pc_branch_unit_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
  .clk(clk), .rst(rst), .fetch_en(fetch_en), .br_req(br_req),
  .zero_flag(zero_flag), .br_offset(br_offset),
  .fetch_addr(fetch_addr), .br_taken(br_taken)
);

// File: tb/pc_branch_unit_test.sv
`timescale 1ns/1ps
module pc_branch_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fetch_en = 1'b0;
  logic        br_req = 1'b0;
  logic        zero_flag = 1'b0;
  logic [7:0]  br_offset = 8'h00;
  logic [15:0] fetch_addr;
  logic        br_taken;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] model = 16'h0000;

  always #10 clk = ~clk;

  pc_branch_unit uut (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .br_req(br_req),
    .zero_flag(zero_flag), .br_offset(br_offset),
    .fetch_addr(fetch_addr), .br_taken(br_taken)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called just after a falling edge; returns just after the next falling edge.
  task automatic step(input logic en, input logic br, input logic z, input logic [7:0] off,
                      input string req);
    logic [15:0] ext;
    fetch_en = en; br_req = br; zero_flag = z; br_offset = off;
    #2;
    chk("R4 decision", {31'd0, br_taken}, {31'd0, br & z});
    ext = 16'($signed(off)) << 1;
    if (en) model = (br & z) ? 16'(model + 16'd2 + ext) : 16'(model + 16'd2);
    @(negedge clk);
    chk(req, {16'd0, fetch_addr}, {16'd0, model});
    chk("R8 bit0", {31'd0, fetch_addr[0]}, 32'd0);
  endtask

  initial begin
    #(20.0 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset", {16'd0, fetch_addr}, 32'd0);
    rst = 1'b0;
    model = 16'h0000;

    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0, 8'(i * 7), "R2 increment");

    for (int i = 0; i < 8; i++) step(1'b0, 1'b1, 1'b1, 8'h05, "R3 hold");

    for (int o = 0; o < 256; o++) begin
      step(1'b1, 1'b1, 1'b1, 8'(o), o >= 128 ? "R6 backward target" : "R5 forward target");
      step(1'b1, 1'b1, 1'b0, 8'(o), "R9 request without zero");
      step(1'b1, 1'b0, 1'b1, 8'(o), "R9 zero without request");
      step(1'b0, 1'b1, 1'b1, 8'(o), "R3 hold with branch");
    end

    // synchronous reset while fetching
    fetch_en = 1'b1; br_req = 1'b1; zero_flag = 1'b1; br_offset = 8'h7F; rst = 1'b1;
    @(negedge clk);
    chk("R1 sync reset", {16'd0, fetch_addr}, 32'd0);
    rst = 1'b0;
    model = 16'h0000;

    step(1'b1, 1'b1, 1'b1, 8'h80, "R7 backward wrap");
    chk("R7 wrap value", {16'd0, fetch_addr}, 32'h0000FF02);
    for (int i = 0; i < 127; i++) step(1'b1, 1'b0, 1'b0, 8'h00, "R7 climb");
    chk("R7 top to zero", {16'd0, fetch_addr}, 32'd0);
    step(1'b1, 1'b1, 1'b1, 8'hFF, "R6 minus one");
    chk("R6 minus one value", {16'd0, fetch_addr}, 32'd0);
    step(1'b1, 1'b1, 1'b1, 8'h7F, "R5 max forward");
    chk("R5 max forward value", {16'd0, fetch_addr}, 32'h00000100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule